// File: doc/BRIEF.md
# Slow-Device Bus Wait-State Generator

This block sits beside the address decoder of a simple synchronous 8-bit CPU bus with one clock phase. The CPU holds its current bus cycle while a ready line is low. When the decoder flags an access to a slow peripheral, such as a display controller, the block pulls ready low for a short, selectable number of clock cycles. The access is stretched only for that device. Every other bus cycle runs at full speed.

The stall length is taken per access from a small wait-length input. That input is sampled on the same clock edge as the select, so peripherals of different speeds can each get their own count. The timing is held in a short thermometer shift chain, not in a counter. An arming flag keeps one long select from producing more than one stall. A cycle-start strobe, or a dropped select, lets the next access stall again. A run of accesses to the slow device therefore gets one fresh stall per access, not one merged stall.

Top module: `slowbus_stall_gen`

## Requirements
- R1: When `rst` is sampled high on a clock edge, `rdy_o` is high after that edge, any stall in progress ends, and the block is re-armed.
- R2: `wait_len` is an unsigned count from 0 to `MAX_WAIT` (3 by default, 2 bits). It is read only on the edge that starts a stall, and that value sets the stall length in cycles.
- R3: A stall of length k>0 drives `rdy_o` low after the edge that started it, keeps it low for exactly k consecutive cycles, and drives it high again on the edge that follows.
- R4: When `wait_len` is 0, `rdy_o` stays high for the whole access.
- R5: After a stall ends, a select that is still held does not start a second stall unless `cyc_start` is sampled high.
- R6: If `sel_slow` and `cyc_start` are both high on an edge while `rdy_o` is high, a new stall starts, even if the select never dropped. Back-to-back accesses therefore each get their own stall.
- R7: A stall starts only on an edge where `sel_slow` is high. Once the select has been sampled low, the next select starts a stall without needing `cyc_start`.
- R8: While a stall is running, changes on `wait_len` and `cyc_start` do not change its length.
- R9: With one wait state, each back-to-back slow access takes two clock cycles, which halves the throughput.
- R10: In a 7-cycle byte-move sequence that makes one slow access, the byte takes 8 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; every register updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sel_slow | input | 1 | Slow-device select from the address decoder |
| wait_len | input | 2 | Wait cycles for this access, read with the select |
| cyc_start | input | 1 | Strobe marking the first cycle of a new bus access |
| rdy_o | output | 1 | Ready to the CPU; low means the CPU holds its cycle |

## Verification
A per-cycle vector table drives the select with every wait length from 0 to 3. This separates a chain loaded with the wrong length from one that shifts at the wrong point. The table also holds the select across the end of a stall, both with and without `cyc_start`, to tell re-arming by the strobe apart from an unwanted retrigger. Changing `wait_len` and pulsing `cyc_start` in the middle of a stall shows whether those inputs are wrongly sampled again. The directed runs then model CPU sequences and count clock edges: a run of back-to-back single-wait accesses, and a seven-cycle byte move. Both checks fail if stalls are merged or if the block stretches cycles it should not touch.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

    typedef struct packed {
        logic armed_out;
    } arm_state_t;

    function automatic int unsigned len_width(input int unsigned max_wait);
        return (max_wait < 2) ? 1 : $clog2(max_wait + 1);
    endfunction

endpackage

// File: rtl/wsg_arm.sv
module wsg_arm (
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  logic new_cycle,
    input  logic busy,
    output logic fire
);
    import wsg_pkg::*;

    arm_state_t st_d, st_q;

    always_comb begin
        fire = sel && !busy && (!st_q.armed_out || new_cycle);
        st_d = st_q;
        if (rst) begin
            st_d.armed_out = 1'b0;
            fire           = 1'b0;
        end else if (fire) begin
            st_d.armed_out = 1'b1;
        end else if (!sel) begin
            st_d.armed_out = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

endmodule

// File: rtl/wsg_chain.sv
module wsg_chain #(
    parameter int unsigned MAX_WAIT = 3,
    parameter int unsigned LEN_W    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LEN_W-1:0] len,
    output logic             busy,
    output logic             rdy
);
    typedef struct packed {
        logic [MAX_WAIT-1:0] taps;
        logic                rdy;
    } chain_t;

    chain_t st_d, st_q;
    logic [MAX_WAIT-1:0] shift_nxt;

    genvar gi;
    generate
        for (gi = 0; gi < MAX_WAIT; gi++) begin : g_stage
            if (gi == MAX_WAIT - 1) begin : g_top
                assign shift_nxt[gi] = load ? (32'(len) > gi) : 1'b0;
            end else begin : g_mid
                assign shift_nxt[gi] = load ? (32'(len) > gi) : st_q.taps[gi+1];
            end
        end
    endgenerate

    always_comb begin
        st_d.taps = shift_nxt;
        st_d.rdy  = ~|shift_nxt;
        if (rst) begin
            st_d.taps = '0;
            st_d.rdy  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign busy = |st_q.taps;
    assign rdy  = st_q.rdy;

endmodule

// File: rtl/slowbus_stall_gen.sv
module slowbus_stall_gen #(
    parameter int unsigned MAX_WAIT = 3,
    parameter int unsigned LEN_W    = wsg_pkg::len_width(MAX_WAIT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sel_slow,
    input  logic [LEN_W-1:0] wait_len,
    input  logic             cyc_start,
    output logic             rdy_o
);
    logic chain_busy;
    logic stall_fire;

    wsg_arm arm_i (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel_slow),
        .new_cycle (cyc_start),
        .busy      (chain_busy),
        .fire      (stall_fire)
    );

    wsg_chain #(
        .MAX_WAIT (MAX_WAIT),
        .LEN_W    (LEN_W)
    ) chain_i (
        .clk  (clk),
        .rst  (rst),
        .load (stall_fire),
        .len  (wait_len),
        .busy (chain_busy),
        .rdy  (rdy_o)
    );

endmodule

// File: rtl/wsg_checker.sv
module wsg_checker #(
    parameter int unsigned MAX_WAIT = 3,
    parameter int unsigned LEN_W    = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             sel_slow,
    input logic [LEN_W-1:0] wait_len,
    input logic             cyc_start,
    input logic             rdy_o
);
    localparam int unsigned RUN_W = $clog2(MAX_WAIT + 2);

    logic             rst_prev_q;
    logic [RUN_W-1:0] low_run_q;

    always_ff @(posedge clk) begin
        rst_prev_q <= rst;
        if (rst || rdy_o) low_run_q <= '0;
        else              low_run_q <= low_run_q + 1'b1;
    end

    // R1: ready is high on the edge after a reset edge
    always_ff @(posedge clk) begin
        if (rst_prev_q === 1'b1) begin
            assert_reset_ready_R1: assert (rdy_o);
        end
    end

    // R3: a low run never exceeds MAX_WAIT cycles
    always_ff @(posedge clk) begin
        if (!rst && rst_prev_q === 1'b0 && !rdy_o) begin
            assert_run_limit_R3: assert (32'(low_run_q) < MAX_WAIT);
        end
    end

    assert_zero_wait_R4: assert property (@(posedge clk) disable iff (rst)
        (rdy_o && sel_slow && wait_len == '0) |=> rdy_o);

    assert_strobe_restall_R6: assert property (@(posedge clk) disable iff (rst)
        (rdy_o && sel_slow && wait_len != '0 && cyc_start) |=> !rdy_o);

    assert_no_select_no_stall_R7: assert property (@(posedge clk) disable iff (rst)
        (rdy_o && !sel_slow) |=> rdy_o);

endmodule

bind slowbus_stall_gen wsg_checker #(
    .MAX_WAIT (MAX_WAIT),
    .LEN_W    (LEN_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .sel_slow  (sel_slow),
    .wait_len  (wait_len),
    .cyc_start (cyc_start),
    .rdy_o     (rdy_o)
);

// File: tb/slowbus_stall_gen_tb.sv
module slowbus_stall_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sel_slow = 1'b0;
    logic [1:0] wait_len = 2'd0;
    logic       cyc_start = 1'b0;
    logic       rdy_o;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    always #5 clk = ~clk;

    slowbus_stall_gen dut_i (
        .clk       (clk),
        .rst       (rst),
        .sel_slow  (sel_slow),
        .wait_len  (wait_len),
        .cyc_start (cyc_start),
        .rdy_o     (rdy_o)
    );

    // row: {rst, sel, wait_len[1:0], cyc_start, expected rdy after edge}
    localparam int NV = 21;
    localparam logic [5:0] VEC [NV] = '{
        6'b1_0_00_0_1, // R1 reset
        6'b0_0_00_0_1,
        6'b0_1_01_1_0, // R3 one wait
        6'b0_1_01_0_1,
        6'b0_1_01_0_1, // R5 held select, no retrigger
        6'b0_0_00_0_1,
        6'b0_1_11_1_0, // R2 three waits
        6'b0_1_00_1_0, // R8 changes ignored
        6'b0_1_00_0_0,
        6'b0_1_00_0_1,
        6'b0_1_00_0_1, // R5
        6'b0_1_10_1_0, // R6 back-to-back via strobe
        6'b0_1_10_0_0,
        6'b0_1_10_0_1,
        6'b0_0_00_0_1,
        6'b0_1_00_1_1, // R4 zero waits
        6'b0_1_00_0_1,
        6'b0_0_00_0_1,
        6'b0_1_10_0_0, // R7 rearmed by dropped select
        6'b0_1_00_0_0,
        6'b0_0_00_0_1
    };

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic r, input logic s, input logic [1:0] w, input logic c);
        rst = r; sel_slow = s; wait_len = w; cyc_start = c;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        checks++;
        fails++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        int edges;
        #2;
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][5], VEC[i][4], VEC[i][3:2], VEC[i][1]);
            tick();
            check($sformatf("R1-table row %0d", i) == "" ? "" : $sformatf("vec%0d R3", i),
                  32'(rdy_o), 32'(VEC[i][0]));
        end

        // R1: reset in the middle of a stall
        drive(0, 1, 2'd3, 1); tick();
        check("R1 stall begins", 32'(rdy_o), 0);
        drive(1, 1, 2'd3, 0); tick();
        check("R1 reset ends stall", 32'(rdy_o), 1);
        drive(0, 0, 2'd0, 0); tick();
        check("R1 idle after reset", 32'(rdy_o), 1);

        // R9: four back-to-back single-wait accesses
        edges = 0;
        for (int a = 0; a < 4; a++) begin
            drive(0, 1, 2'd1, 1); tick(); edges++;
            while (!rdy_o && edges < 50) begin
                drive(0, 1, 2'd1, 0); tick(); edges++;
            end
        end
        check("R9 cycles for 4 accesses", 32'(edges), 8);
        drive(0, 0, 2'd0, 0); tick();

        // R10: seven-cycle byte move with one slow write
        edges = 0;
        for (int c = 0; c < 7; c++) begin
            if (c == 3) begin
                drive(0, 1, 2'd1, 1); tick(); edges++;
                while (!rdy_o && edges < 50) begin
                    drive(0, 1, 2'd1, 0); tick(); edges++;
                end
            end else begin
                drive(0, 0, 2'd1, 1); tick(); edges++;
                check("R7 fast cycle not stretched", 32'(rdy_o), 1);
            end
        end
        check("R10 cycles per byte", 32'(edges), 8);

        finish_run();
    end

endmodule